// File: doc/BRIEF.md
# Round-Robin Bus Arbiter with Grant Parking

This block decides which of N initiators may drive a shared path to one target. Every port gets a three-bit priority word, built from three things: whether the port is requesting, whether it was the last owner and is now idle, and whether its number is above the last owner's. A maximum-select comparator then picks the port with the largest word. When several ports share the largest word, the lowest-numbered one is picked. Because the words depend on the last owner, requesting ports are served in cyclic order.

A grant is held for the whole transaction. Arbitration happens again only on the cycle the owner signals completion with `done`. When no initiator is requesting, the largest word belongs to the previous owner, so the grant stays parked there. That owner can then start its next transaction without first waiting to win arbitration. The grant comes out both as a one-hot vector and as a binary index.

Top module: `rr_park_arbiter`

## Requirements
- R1: While `rst_n` is low, and after its release until the first arbitration, `gnt` is 4'b0001 and `gnt_idx` is 0. In this state port 0 is the last owner and the arbiter is idle.
- R2: `gnt` always has exactly one bit set, and that bit is at position `gnt_idx`.
- R3: A requesting port always beats the parked idle owner. Example: the grant is parked on port 2 with no requests, and then only port 0 requests. The next grant goes to port 0.
- R4: When the arbiter re-arbitrates with `req` all zero, the grant stays on the last owner. It keeps staying there on every following cycle until some port requests.
- R5: Among requesting ports, a port numbered above the last owner beats any port numbered at or below it. The last owner itself does not count as above.
- R6: When requesting ports have equal priority words, the lowest-numbered one is granted. Example: from reset, `req`=4'b0110 grants port 1.
- R7: While a transaction is in progress (a requesting port holds the grant and `done` is low), `gnt` and `gnt_idx` do not change, whatever `req` does.
- R8: Arbitration happens on a clock edge where the arbiter is idle or `done` is high. The new grant shows one cycle after that edge. If any request is pending, the new grant goes to a requesting port.
- R9: If every port requests continuously and each transaction ends with one `done` pulse, the grants follow 1, 2, 3, 0, 1, 2, 3, 0 from reset. Each port is served once before any port is served twice.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | N | Request vector, bit i set while initiator i wants the target |
| done | input | 1 | Transaction-complete strobe from the current owner |
| gnt | output | N | One-hot grant vector |
| gnt_idx | output | IW | Binary index of the granted initiator |

## Verification
The bench builds the arbiter with the default of four ports, so IW is 2. This size is enough to reach every priority word class at once: ports below the last owner, the owner itself, and ports above it. It also covers the wrap from port 3 back to port 0, and ties among both the above-owner group and the below-owner group. With four ports a full rotation takes only four transactions, so fairness, parking, the requesting-beats-parked case and holding during a transaction can all be checked in short, separate scenarios.

// File: rtl/rr_arb_pkg.sv
package rr_arb_pkg;

  // Priority word: {pending, idle last owner, above last owner}
  function automatic logic [2:0] prio_word(input logic pending,
                                           input logic is_last,
                                           input logic above_last);
    return {pending, is_last & ~pending, above_last};
  endfunction

endpackage

// File: rtl/rr_prio_gen.sv
module rr_prio_gen
  import rr_arb_pkg::*;
#(
  parameter int N  = 4,
  parameter int IW = 2
) (
  input  logic [N-1:0]      req,
  input  logic [IW-1:0]     last_idx,
  output logic [N-1:0][2:0] prio
);

  for (genvar g = 0; g < N; g++) begin : g_port
    assign prio[g] = prio_word(req[g],
                               last_idx == IW'(g),
                               IW'(g) > last_idx);
  end

endmodule

// File: rtl/rr_max_select.sv
module rr_max_select #(
  parameter int N  = 4,
  parameter int IW = 2
) (
  input  logic [N-1:0][2:0] prio,
  output logic [IW-1:0]     win_idx
);

  logic [2:0] best;

  // Scan downward; ">=" lets a lower port take over on a tie.
  always_comb begin
    best    = prio[N-1];
    win_idx = IW'(N-1);
    for (int i = N - 2; i >= 0; i--) begin
      if (prio[i] >= best) begin
        best    = prio[i];
        win_idx = IW'(i);
      end
    end
  end

endmodule

// File: rtl/rr_grant_reg.sv
module rr_grant_reg #(
  parameter int IW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          arb_en,
  input  logic [IW-1:0] win_idx,
  input  logic          win_req,
  output logic [IW-1:0] cur_idx,
  output logic          busy
);

  // cur_idx doubles as the last-grant register and the parking spot.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_idx <= '0;
      busy    <= 1'b0;
    end else if (arb_en) begin
      cur_idx <= win_idx;
      busy    <= win_req;
    end
  end

endmodule

// File: rtl/rr_park_arbiter.sv
module rr_park_arbiter #(
  parameter int N  = 4,
  parameter int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  req,
  input  logic          done,
  output logic [N-1:0]  gnt,
  output logic [IW-1:0] gnt_idx
);

  logic [N-1:0][2:0] prio;
  logic [IW-1:0]     win_idx;
  logic [IW-1:0]     cur_idx;
  logic              busy;
  logic              arb_en;
  logic              win_req;

  assign arb_en  = !busy || done;
  assign win_req = req[win_idx];

  rr_prio_gen #(.N(N), .IW(IW)) u_prio (
    .req      (req),
    .last_idx (cur_idx),
    .prio     (prio)
  );

  rr_max_select #(.N(N), .IW(IW)) u_sel (
    .prio    (prio),
    .win_idx (win_idx)
  );

  rr_grant_reg #(.IW(IW)) u_reg (
    .clk     (clk),
    .rst_n   (rst_n),
    .arb_en  (arb_en),
    .win_idx (win_idx),
    .win_req (win_req),
    .cur_idx (cur_idx),
    .busy    (busy)
  );

  for (genvar g = 0; g < N; g++) begin : g_dec
    assign gnt[g] = (cur_idx == IW'(g));
  end

  assign gnt_idx = cur_idx;

endmodule

// File: rtl/rr_park_arbiter_chk.sv
module rr_park_arbiter_chk #(
  parameter int N  = 4,
  parameter int IW = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic [N-1:0]  req,
  input logic          done,
  input logic [N-1:0]  gnt,
  input logic [IW-1:0] gnt_idx,
  input logic          busy,
  input logic          arb_en,
  input logic [IW-1:0] win_idx
);

  AST_GNT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(gnt) == 1);                                            // R2

  AST_IDX_AGREES: assert property (@(posedge clk) disable iff (!rst_n)
    gnt[gnt_idx]);                                                    // R2

  AST_HOLD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !done |=> $stable(gnt_idx) && busy);                      // R7

  AST_PARK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    arb_en && (req == '0) |=> $stable(gnt_idx) && !busy);             // R4

  AST_WIN_REQUESTS: assert property (@(posedge clk) disable iff (!rst_n)
    (req != '0) |-> req[win_idx]);                                    // R8

  AST_TAKE_WIN: assert property (@(posedge clk) disable iff (!rst_n)
    arb_en |=> gnt_idx == $past(win_idx));                            // R8

endmodule

bind rr_park_arbiter rr_park_arbiter_chk #(.N(N), .IW(IW)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .req     (req),
  .done    (done),
  .gnt     (gnt),
  .gnt_idx (gnt_idx),
  .busy    (busy),
  .arb_en  (arb_en),
  .win_idx (win_idx)
);

// File: tb/rr_park_arbiter_bench.sv
`timescale 1ns/1ps
module rr_park_arbiter_bench;

  localparam int N  = 4;
  localparam int IW = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  req = '0;
  logic          done = 1'b0;
  logic [N-1:0]  gnt;
  logic [IW-1:0] gnt_idx;

  int checks = 0;
  int failures = 0;

  always #4 clk = ~clk;

  rr_park_arbiter #(.N(N)) u_rr_park_arbiter (
    .clk     (clk),
    .rst_n   (rst_n),
    .req     (req),
    .done    (done),
    .gnt     (gnt),
    .gnt_idx (gnt_idx)
  );

  // Bench model: next requester cyclically after last, else stay on last.
  function automatic int rr_expect(input int last, input logic [N-1:0] r);
    if (r == '0) return last;
    for (int i = last + 1; i < N; i++) if (r[i]) return i;
    for (int i = 0; i < N; i++) if (r[i]) return i;
    return last;
  endfunction

  task automatic check_grant(input int exp, input string tag);
    logic [N-1:0] exp_vec;
    exp_vec = N'(1) << exp;
    checks++;
    if (gnt !== exp_vec || int'(gnt_idx) != exp) begin
      failures++;
      $display("FAIL %s: gnt=%b idx=%0d expected gnt=%b idx=%0d",
               tag, gnt, gnt_idx, exp_vec, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic apply_reset();
    @(negedge clk);
    rst_n = 1'b0; req = '0; done = 1'b0;
    cyc(2);
    rst_n = 1'b1;
  endtask

  // End the current transaction with a one-cycle done pulse under request r.
  task automatic finish_xfer(input logic [N-1:0] r);
    req = r; done = 1'b1;
    cyc(1);
    done = 1'b0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    rst_n = 1'b0; req = '0; done = 1'b0;
    cyc(2);
    check_grant(0, "R1 during reset");
    rst_n = 1'b1;
    cyc(1);
    check_grant(0, "R1 after release, idle park on port 0");
  endtask

  task automatic t_round_robin();
    int last;
    int exp_seq[8] = '{1, 2, 3, 0, 1, 2, 3, 0};
    apply_reset();
    last = 0;
    req = '1;
    cyc(1);
    last = rr_expect(last, req);
    check_grant(last, "R9 first grant");
    checks++;
    if (last != exp_seq[0]) begin
      failures++;
      $display("FAIL R9 model: got %0d expected %0d", last, exp_seq[0]);
    end
    for (int k = 1; k < 8; k++) begin
      cyc(2);
      check_grant(last, "R7 held during transaction");
      finish_xfer('1);
      last = rr_expect(last, '1);
      check_grant(exp_seq[k], "R9 rotation order");
    end
  endtask

  task automatic t_hold();
    apply_reset();
    req = 4'b0010;
    cyc(1);
    check_grant(1, "R8 single requester");
    req = 4'b1100;
    cyc(3);
    check_grant(1, "R7 request change ignored while busy");
    req = 4'b0000;
    cyc(2);
    check_grant(1, "R7 request drop ignored while busy");
    finish_xfer(4'b1100);
    check_grant(2, "R5 above-last requester after done");
  endtask

  task automatic t_park();
    apply_reset();
    req = 4'b0100;
    cyc(1);
    check_grant(2, "R8 grant port 2");
    finish_xfer(4'b0000);
    check_grant(2, "R4 park on last owner");
    cyc(4);
    check_grant(2, "R4 park persists");
    req = 4'b0100;
    cyc(1);
    check_grant(2, "R4 parked owner regrants itself");
    finish_xfer(4'b0000);
    req = 4'b0001;
    cyc(1);
    check_grant(0, "R3 requester beats parked idle owner");
  endtask

  task automatic t_tie_and_order();
    apply_reset();
    req = 4'b0110;
    cyc(1);
    check_grant(1, "R6 tie among above-last ports");
    finish_xfer(4'b0100);
    check_grant(2, "R8 grant port 2");
    finish_xfer(4'b0011);
    check_grant(0, "R6 tie among below-last ports");
    finish_xfer(4'b1001);
    check_grant(3, "R5 above-last beats last owner");
    finish_xfer(4'b0010);
    check_grant(1, "R8 grant port 1");
    finish_xfer(4'b0011);
    check_grant(0, "R5 last owner has no above bit");
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_round_robin();
        t_hold();
        t_park();
        t_tie_and_order();
        cyc(2);
      end
      begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog: run did not finish");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule